// File: doc/BRIEF.md
# Inflight Packet Credit Release Unit

This block keeps two tables of inflight packet counts for a load balancer. One table has one counter per notification ring. The other has one counter per bucket. A 64-bit memory-mapped store returns credit. Its address selects a ring, a bucket, and which of the two tables to touch. Its data carries the number of packets being released. One store can decrement the ring counter, the bucket counter, both, or neither.

A separate increment port adds inflight packets to either table, so a test environment can build up counts. A read port returns a ring counter and the packed status entry of a bucket. Each bucket status entry holds the assigned ring, the count, a group and a mode. A configuration port writes the ring, group and mode of a bucket.

The service-domain field of an accepted store is decoded and passed out one cycle later. No permission check is made on it. Counters never wrap. A release larger than the count clamps the counter at zero and sets an error flag that stays set until reset.

Top module: `crCreditRelease`

## Requirements
- R1: A store is accepted only when address bits [28:26] hold 4. A store with any other value there changes no counter and produces no service-domain pulse.
- R2: Address bits [10:3] select the ring counter. Address bits [23:11] select the 13-bit bucket index.
- R3: Address bit 24 enables the decrement of the selected ring counter. Address bit 25 enables the decrement of the selected bucket counter. Either, both or neither may be set, and a table whose bit is clear keeps its value.
- R4: The released amount is data bits [15:0]. Data bits [63:16] have no effect.
- R5: One clock after an accepted store, svcDomValid is high for one cycle and svcDomIdx equals address bits [39:35] of that store.
- R6: A release larger than the current count sets that counter to zero. In the same clock edge, underflowErr is set. underflowErr stays set until reset.
- R7: When an increment and a release hit the same counter in the same cycle, the counter takes the net result, count + increment − release.
- R8: rdBucketEntry packs the bucket entry as ring in [7:0], count in [23:8], group in [28:24] and mode in [31:29]. A configuration write sets the ring, group and mode and leaves the count unchanged.
- R9: Bucket indexes at or beyond BKT_DEPTH are ignored by increment, release and configuration writes, and read back as zero.
- R10: After reset, every counter, every bucket entry, underflowErr and svcDomValid are zero.
- R11: An increment (incBucket=0 for the ring table, 1 for the bucket table) adds incAmount to the counter at incIdx. The result saturates at 65535 without setting underflowErr.
- R12: A counter changes only on a clock edge with a matching increment or an accepted, enabled release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Store strobe |
| wrAddr | input | 64 | Store address |
| wrData | input | 64 | Store data |
| incValid | input | 1 | Increment strobe |
| incBucket | input | 1 | Increment target: 0 ring table, 1 bucket table |
| incIdx | input | 13 | Increment index (low 8 bits for rings) |
| incAmount | input | 16 | Packets added |
| cfgValid | input | 1 | Bucket configuration strobe |
| cfgBucket | input | 13 | Bucket being configured |
| cfgRing | input | 8 | Ring assigned to the bucket |
| cfgGroup | input | 5 | Group of the bucket |
| cfgMode | input | 3 | Mode of the bucket |
| rdRingIdx | input | 8 | Ring counter to read |
| rdRingCount | output | 16 | Count of the selected ring |
| rdBucketIdx | input | 13 | Bucket entry to read |
| rdBucketEntry | output | 32 | Packed status entry of the selected bucket |
| svcDomValid | output | 1 | Pulse one cycle after an accepted store |
| svcDomIdx | output | 5 | Service-domain index of that store |
| underflowErr | output | 1 | Sticky release-underflow flag |

## Verification
The counter properties treat rdRingIdx as a probe. They only check cycles in which the read index was held steady, so the stimulus keeps the read index constant across each edge it samples. The properties also assume wrAddr and wrData are defined whenever wrValid is high. The bench therefore drives every field of a store and leaves the unused address bits at zero. Since R1 depends on the region field alone, the vectors use region values other than 4 together with otherwise legal addresses.

// File: rtl/crPkg.sv
package crPkg;
  localparam int RingIdxW = 8;
  localparam int BktIdxW  = 13;
  localparam int CntW     = 16;
  localparam int SvcW     = 5;

  // address field positions decoded by the control path
  localparam int RingLsb   = 3;
  localparam int BktLsb    = 11;
  localparam int RingEnBit = 24;
  localparam int BktEnBit  = 25;
  localparam int RegionLsb = 26;
  localparam int SvcLsb    = 35;
  localparam logic [2:0] RegionRelease = 3'd4;

  typedef struct packed {
    logic                taken;
    logic                relRing;
    logic                relBucket;
    logic [RingIdxW-1:0] ringIdx;
    logic [BktIdxW-1:0]  bucketIdx;
    logic [CntW-1:0]     amount;
    logic [SvcW-1:0]     svcDom;
  } relStrobe_t;
endpackage

// File: rtl/crRelCtrl.sv
module crRelCtrl
  import crPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [63:0]       wrAddr,
  input  logic [63:0]       wrData,
  output relStrobe_t        strobe,
  output logic              svcDomValid,
  output logic [SvcW-1:0]   svcDomIdx
);
  logic [2:0] region;
  logic       unusedBits;

  assign region     = wrAddr[RegionLsb +: 3];
  assign unusedBits = ^{wrAddr[63:SvcLsb+SvcW], wrAddr[SvcLsb-1:RegionLsb+3],
                        wrAddr[RingLsb-1:0], wrData[63:CntW]};

  always_comb begin
    strobe.taken     = wrValid && (region == RegionRelease);
    strobe.relRing   = strobe.taken && wrAddr[RingEnBit];
    strobe.relBucket = strobe.taken && wrAddr[BktEnBit];
    strobe.ringIdx   = wrAddr[RingLsb +: RingIdxW];
    strobe.bucketIdx = wrAddr[BktLsb +: BktIdxW];
    strobe.amount    = wrData[CntW-1:0];
    strobe.svcDom    = wrAddr[SvcLsb +: SvcW];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      svcDomValid <= 1'b0;
      svcDomIdx   <= '0;
    end else begin
      svcDomValid <= strobe.taken;
      if (strobe.taken) svcDomIdx <= strobe.svcDom;
    end
  end
endmodule

// File: rtl/crCreditTable.sv
module crCreditTable #(
  parameter int DEPTH = 64,
  parameter int IDXW  = 13,
  parameter int CNTW  = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            incEn,
  input  logic [IDXW-1:0] incIdx,
  input  logic [CNTW-1:0] incAmt,
  input  logic            relEn,
  input  logic [IDXW-1:0] relIdx,
  input  logic [CNTW-1:0] relAmt,
  input  logic [IDXW-1:0] rdIdx,
  output logic [CNTW-1:0] rdVal,
  output logic            underflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CNTW-1:0] cnt [DEPTH];
  logic incOk, relOk, rdOk;
  logic [AW-1:0] incA, relA, rdA;
  logic incHit, relHit, sameHit;
  logic [CNTW:0] incRes, relRes;

  generate
    if (DEPTH >= (1 << IDXW)) begin : gFull
      assign incOk = 1'b1;
      assign relOk = 1'b1;
      assign rdOk  = 1'b1;
    end else begin : gPart
      assign incOk = int'(incIdx) < DEPTH;
      assign relOk = int'(relIdx) < DEPTH;
      assign rdOk  = int'(rdIdx) < DEPTH;
    end
  endgenerate

  assign incA = incIdx[AW-1:0];
  assign relA = relIdx[AW-1:0];
  assign rdA  = rdIdx[AW-1:0];

  // returns {underflow, saturated value}
  function automatic logic [CNTW:0] satStep(input logic [CNTW-1:0] cur,
                                            input logic [CNTW-1:0] add,
                                            input logic [CNTW-1:0] sub);
    logic [CNTW+1:0] s;
    s = {2'b00, cur} + {2'b00, add} - {2'b00, sub};
    if (s[CNTW+1])     return {1'b1, {CNTW{1'b0}}};
    else if (s[CNTW])  return {1'b0, {CNTW{1'b1}}};
    else               return {1'b0, s[CNTW-1:0]};
  endfunction

  always_comb begin
    incHit  = incEn && incOk;
    relHit  = relEn && relOk;
    sameHit = incHit && relHit && (incA == relA);
    incRes  = satStep(cnt[incA], incAmt, '0);
    relRes  = satStep(cnt[relA], sameHit ? incAmt : '0, relAmt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) cnt[i] <= '0;
    end else begin
      if (incHit && !sameHit) cnt[incA] <= incRes[CNTW-1:0];
      if (relHit)             cnt[relA] <= relRes[CNTW-1:0];
    end
  end

  assign underflow = relHit && relRes[CNTW];
  assign rdVal     = rdOk ? cnt[rdA] : '0;
endmodule

// File: rtl/crRelDatapath.sv
module crRelDatapath
  import crPkg::*;
#(
  parameter int BKT_DEPTH = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  relStrobe_t          strobe,
  input  logic                incValid,
  input  logic                incBucket,
  input  logic [BktIdxW-1:0]  incIdx,
  input  logic [CntW-1:0]     incAmount,
  input  logic                cfgValid,
  input  logic [BktIdxW-1:0]  cfgBucket,
  input  logic [RingIdxW-1:0] cfgRing,
  input  logic [4:0]          cfgGroup,
  input  logic [2:0]          cfgMode,
  input  logic [RingIdxW-1:0] rdRingIdx,
  output logic [CntW-1:0]     rdRingCount,
  input  logic [BktIdxW-1:0]  rdBucketIdx,
  output logic [31:0]         rdBucketEntry,
  output logic                underflowErr
);
  localparam int RingDepth = 1 << RingIdxW;
  localparam int BAW       = (BKT_DEPTH > 1) ? $clog2(BKT_DEPTH) : 1;

  logic ringUnder, bktUnder;
  logic [CntW-1:0] bktCount;
  logic [RingIdxW-1:0] ringOf  [BKT_DEPTH];
  logic [4:0]          groupOf [BKT_DEPTH];
  logic [2:0]          modeOf  [BKT_DEPTH];
  logic cfgOk, rdOk;
  logic [BAW-1:0] cfgA, rdA;

  crCreditTable #(.DEPTH(RingDepth), .IDXW(RingIdxW), .CNTW(CntW)) u_ringTbl (
    .clk(clk), .rstN(rstN),
    .incEn(incValid && !incBucket), .incIdx(incIdx[RingIdxW-1:0]), .incAmt(incAmount),
    .relEn(strobe.relRing), .relIdx(strobe.ringIdx), .relAmt(strobe.amount),
    .rdIdx(rdRingIdx), .rdVal(rdRingCount), .underflow(ringUnder)
  );

  crCreditTable #(.DEPTH(BKT_DEPTH), .IDXW(BktIdxW), .CNTW(CntW)) u_bktTbl (
    .clk(clk), .rstN(rstN),
    .incEn(incValid && incBucket), .incIdx(incIdx), .incAmt(incAmount),
    .relEn(strobe.relBucket), .relIdx(strobe.bucketIdx), .relAmt(strobe.amount),
    .rdIdx(rdBucketIdx), .rdVal(bktCount), .underflow(bktUnder)
  );

  assign cfgOk = int'(cfgBucket) < BKT_DEPTH;
  assign rdOk  = int'(rdBucketIdx) < BKT_DEPTH;
  assign cfgA  = cfgBucket[BAW-1:0];
  assign rdA   = rdBucketIdx[BAW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < BKT_DEPTH; i++) begin
        ringOf[i]  <= '0;
        groupOf[i] <= '0;
        modeOf[i]  <= '0;
      end
      underflowErr <= 1'b0;
    end else begin
      if (cfgValid && cfgOk) begin
        ringOf[cfgA]  <= cfgRing;
        groupOf[cfgA] <= cfgGroup;
        modeOf[cfgA]  <= cfgMode;
      end
      if (ringUnder || bktUnder) underflowErr <= 1'b1;
    end
  end

  assign rdBucketEntry = rdOk ? {modeOf[rdA], groupOf[rdA], bktCount, ringOf[rdA]} : 32'd0;
endmodule

// File: rtl/crCreditRelease.sv
module crCreditRelease #(
  parameter int BKT_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  input  logic [63:0] wrAddr,
  input  logic [63:0] wrData,
  input  logic        incValid,
  input  logic        incBucket,
  input  logic [12:0] incIdx,
  input  logic [15:0] incAmount,
  input  logic        cfgValid,
  input  logic [12:0] cfgBucket,
  input  logic [7:0]  cfgRing,
  input  logic [4:0]  cfgGroup,
  input  logic [2:0]  cfgMode,
  input  logic [7:0]  rdRingIdx,
  output logic [15:0] rdRingCount,
  input  logic [12:0] rdBucketIdx,
  output logic [31:0] rdBucketEntry,
  output logic        svcDomValid,
  output logic [4:0]  svcDomIdx,
  output logic        underflowErr
);
  crPkg::relStrobe_t strobe;

  crRelCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .svcDomValid(svcDomValid), .svcDomIdx(svcDomIdx)
  );

  crRelDatapath #(.BKT_DEPTH(BKT_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .incValid(incValid), .incBucket(incBucket), .incIdx(incIdx), .incAmount(incAmount),
    .cfgValid(cfgValid), .cfgBucket(cfgBucket), .cfgRing(cfgRing),
    .cfgGroup(cfgGroup), .cfgMode(cfgMode),
    .rdRingIdx(rdRingIdx), .rdRingCount(rdRingCount),
    .rdBucketIdx(rdBucketIdx), .rdBucketEntry(rdBucketEntry),
    .underflowErr(underflowErr)
  );
endmodule

// File: rtl/crCreditReleaseChk.sv
module crCreditReleaseChk (
  input logic        clk,
  input logic        rstN,
  input logic        wrValid,
  input logic [63:0] wrAddr,
  input logic        incValid,
  input logic [7:0]  rdRingIdx,
  input logic [15:0] rdRingCount,
  input logic        svcDomValid,
  input logic [4:0]  svcDomIdx,
  input logic        underflowErr
);
  logic accepted;
  assign accepted = wrValid && (wrAddr[28:26] == 3'd4);

  AST_OFF_REGION_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !accepted |=> !svcDomValid); // R1

  AST_SVC_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> svcDomValid && (svcDomIdx == $past(wrAddr[39:35]))); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    underflowErr |=> underflowErr); // R6

  AST_RING_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && wrAddr[24] && !incValid && (rdRingIdx == wrAddr[10:3]))
      |=> (!$stable(rdRingIdx) || (rdRingCount <= $past(rdRingCount)))); // R3

  AST_RING_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!wrValid && !incValid) |=> (!$stable(rdRingIdx) || $stable(rdRingCount))); // R12
endmodule

bind crCreditRelease crCreditReleaseChk u_chk (.*);

// File: tb/crCreditRelease_tb.sv
module crCreditRelease_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrValid;
  logic [63:0] wrAddr, wrData;
  logic        incValid, incBucket;
  logic [12:0] incIdx;
  logic [15:0] incAmount;
  logic        cfgValid;
  logic [12:0] cfgBucket;
  logic [7:0]  cfgRing;
  logic [4:0]  cfgGroup;
  logic [2:0]  cfgMode;
  logic [7:0]  rdRingIdx;
  logic [15:0] rdRingCount;
  logic [12:0] rdBucketIdx;
  logic [31:0] rdBucketEntry;
  logic        svcDomValid;
  logic [4:0]  svcDomIdx;
  logic        underflowErr;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  crCreditRelease u_dut (.*);

  typedef struct packed {
    logic        doInc;
    logic        incBkt;
    logic [12:0] incI;
    logic [15:0] incA;
    logic        doWr;
    logic [2:0]  region;
    logic [7:0]  ring;
    logic [12:0] bkt;
    logic        rEn;
    logic        bEn;
    logic [15:0] rel;
    logic        chkBkt;
    logic [12:0] chkI;
    logic [15:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    // R11 increments
    '{1'b1,1'b0,13'd5,16'd10,  1'b0,3'd4,8'd0,13'd0,1'b0,1'b0,16'd0,  1'b0,13'd5,16'd10, 8'd11},
    '{1'b1,1'b1,13'd7,16'd20,  1'b0,3'd4,8'd0,13'd0,1'b0,1'b0,16'd0,  1'b1,13'd7,16'd20, 8'd11},
    // R3 enable combinations
    '{1'b0,1'b0,13'd0,16'd0,   1'b1,3'd4,8'd5,13'd7,1'b1,1'b0,16'd3,  1'b0,13'd5,16'd7,  8'd3},
    '{1'b0,1'b0,13'd0,16'd0,   1'b1,3'd4,8'd5,13'd7,1'b0,1'b1,16'd4,  1'b1,13'd7,16'd16, 8'd3},
    '{1'b0,1'b0,13'd0,16'd0,   1'b1,3'd4,8'd5,13'd7,1'b0,1'b0,16'd1,  1'b0,13'd5,16'd7,  8'd3},
    '{1'b0,1'b0,13'd0,16'd0,   1'b1,3'd4,8'd5,13'd7,1'b1,1'b1,16'd2,  1'b1,13'd7,16'd14, 8'd3},
    '{1'b0,1'b0,13'd0,16'd0,   1'b0,3'd4,8'd0,13'd0,1'b0,1'b0,16'd0,  1'b0,13'd5,16'd5,  8'd3},
    // R1 other regions
    '{1'b0,1'b0,13'd0,16'd0,   1'b1,3'd5,8'd5,13'd7,1'b1,1'b1,16'd5,  1'b0,13'd5,16'd5,  8'd1},
    '{1'b0,1'b0,13'd0,16'd0,   1'b1,3'd0,8'd5,13'd7,1'b1,1'b1,16'd5,  1'b1,13'd7,16'd14, 8'd1},
    // R7 same-cycle net change
    '{1'b1,1'b0,13'd9,16'd100, 1'b1,3'd4,8'd9,13'd0,1'b1,1'b0,16'd30, 1'b0,13'd9,16'd70, 8'd7},
    '{1'b1,1'b1,13'd7,16'd6,   1'b1,3'd4,8'd0,13'd7,1'b0,1'b1,16'd20, 1'b1,13'd7,16'd0,  8'd7},
    // R2 field positions, R4 data upper bits
    '{1'b1,1'b0,13'd200,16'd50,1'b0,3'd4,8'd0,13'd0,1'b0,1'b0,16'd0,  1'b0,13'd200,16'd50,8'd2},
    '{1'b0,1'b0,13'd0,16'd0,   1'b1,3'd4,8'd200,13'd0,1'b1,1'b0,16'd8,1'b0,13'd200,16'd42,8'd4},
    '{1'b1,1'b1,13'd63,16'd9,  1'b0,3'd4,8'd0,13'd0,1'b0,1'b0,16'd0,  1'b1,13'd63,16'd9, 8'd2},
    '{1'b0,1'b0,13'd0,16'd0,   1'b1,3'd4,8'd0,13'd63,1'b0,1'b1,16'd9, 1'b1,13'd63,16'd0, 8'd2}
  };

  function automatic logic [63:0] mkAddr(input logic [2:0] region, input logic [7:0] ring,
                                         input logic [12:0] bkt, input logic rEn,
                                         input logic bEn, input logic [4:0] svc);
    logic [63:0] a;
    a = '0;
    a[10:3]  = ring;
    a[23:11] = bkt;
    a[24]    = rEn;
    a[25]    = bEn;
    a[28:26] = region;
    a[39:35] = svc;
    return a;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idleIn();
    wrValid = 1'b0; wrAddr = '0; wrData = '0;
    incValid = 1'b0; incBucket = 1'b0; incIdx = '0; incAmount = '0;
    cfgValid = 1'b0; cfgBucket = '0; cfgRing = '0; cfgGroup = '0; cfgMode = '0;
  endtask

  // apply inputs already set, take one edge, return at the next falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idleIn();
  endtask

  task automatic wr(input logic [2:0] region, input logic [7:0] ring, input logic [12:0] bkt,
                    input logic rEn, input logic bEn, input logic [15:0] amt,
                    input logic [4:0] svc);
    wrValid = 1'b1;
    wrAddr  = mkAddr(region, ring, bkt, rEn, bEn, svc);
    wrData  = {48'hA5C3_0F1E_77B2, amt};
  endtask

  task automatic inc(input logic toBkt, input logic [12:0] idx, input logic [15:0] amt);
    incValid = 1'b1; incBucket = toBkt; incIdx = idx; incAmount = amt;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idleIn();
    rdRingIdx = '0; rdBucketIdx = '0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R10 reset state
    check("R10", "ring0", 32'(rdRingCount), 32'd0);
    check("R10", "bucket0", rdBucketEntry, 32'd0);
    check("R10", "err", 32'(underflowErr), 32'd0);
    check("R10", "svcValid", 32'(svcDomValid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      if (v.doInc) inc(v.incBkt, v.incI, v.incA);
      if (v.doWr) wr(v.region, v.ring, v.bkt, v.rEn, v.bEn, v.rel, 5'(i));
      tick();
      rdRingIdx = v.chkI[7:0];
      rdBucketIdx = v.chkI;
      #1;
      if (v.chkBkt) check($sformatf("R%0d", v.req), $sformatf("vec%0d bucket", i),
                          32'(rdBucketEntry[23:8]), 32'(v.exp));
      else          check($sformatf("R%0d", v.req), $sformatf("vec%0d ring", i),
                          32'(rdRingCount), 32'(v.exp));
    end
    check("R6", "no underflow yet", 32'(underflowErr), 32'd0);

    // R5 service-domain pulse
    wr(3'd4, 8'd0, 13'd0, 1'b0, 1'b0, 16'd0, 5'd21);
    tick();
    #1;
    check("R5", "svc valid", 32'(svcDomValid), 32'd1);
    check("R5", "svc idx", 32'(svcDomIdx), 32'd21);
    // R1 off-region store gives no pulse
    wr(3'd6, 8'd0, 13'd0, 1'b1, 1'b1, 16'd1, 5'd3);
    tick();
    #1;
    check("R1", "svc quiet", 32'(svcDomValid), 32'd0);

    // R11 saturation at the top
    rdRingIdx = 8'd1;
    inc(1'b0, 13'd1, 16'hFFFF);
    tick();
    inc(1'b0, 13'd1, 16'd2);
    tick();
    #1;
    check("R11", "ring1 sat", 32'(rdRingCount), 32'hFFFF);
    check("R11", "err clear", 32'(underflowErr), 32'd0);

    // R6 underflow clamps and flags
    rdRingIdx = 8'd9;
    wr(3'd4, 8'd9, 13'd0, 1'b1, 1'b0, 16'd100, 5'd0);
    tick();
    #1;
    check("R6", "ring9 clamp", 32'(rdRingCount), 32'd0);
    check("R6", "err set", 32'(underflowErr), 32'd1);
    tick();
    tick();
    #1;
    check("R6", "err sticky", 32'(underflowErr), 32'd1);

    // R8 entry layout
    cfgValid = 1'b1; cfgBucket = 13'd3; cfgRing = 8'hA5; cfgGroup = 5'h13; cfgMode = 3'd5;
    inc(1'b1, 13'd3, 16'h1234);
    tick();
    rdBucketIdx = 13'd3;
    #1;
    check("R8", "entry3", rdBucketEntry, {3'd5, 5'h13, 16'h1234, 8'hA5});

    // R9 out-of-range buckets
    inc(1'b1, 13'd100, 16'd5);
    cfgValid = 1'b1; cfgBucket = 13'd100; cfgRing = 8'h11; cfgGroup = 5'd1; cfgMode = 3'd1;
    tick();
    wr(3'd4, 8'd0, 13'd67, 1'b0, 1'b1, 16'd1, 5'd0);
    tick();
    rdBucketIdx = 13'd100;
    #1;
    check("R9", "bucket100", rdBucketEntry, 32'd0);
    rdBucketIdx = 13'd36;
    #1;
    check("R9", "alias36", rdBucketEntry, 32'd0);
    rdBucketIdx = 13'd3;
    #1;
    check("R9", "bucket3 kept", rdBucketEntry, {3'd5, 5'h13, 16'h1234, 8'hA5});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule